// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Latch-Off Sequencer

This block manages the overcurrent response of a single PWM channel. Once per PWM period, on the tick, it samples a comparator. The comparator reports whether the sensed low-side current is above its threshold. The block uses that sample to decide whether the next upper-switch pulse may pass. While the comparator stays high, upper pulses are blocked period by period. When the comparator drops, pulses are released again.

The first trip opens an observation window of two phases:

- **Grace phase.** During the first phase, trips only cause pulses to be skipped.
- **Re-trip phase.** A trip during the second phase latches the channel off.

If the re-trip phase ends with no trip, the sequencer goes back to idle and waits for a new first trip. A latched channel keeps its upper pulse blocked and raises a fault flag, which the power-good logic uses to pull its own output low. The latch clears only in two cases: both enable inputs are low on the same clock, or the asynchronous reset is asserted. The reset stands in for a supply cycle.

Top module: `ocp_seq`

## Requirements
- R1: A high comparator sample on a tick blocks `pulse_o` from the clock after that tick until the next tick. `skip_o` is high for that interval.
- R2: A low comparator sample on a tick releases `pulse_o` from the next clock, so that `pulse_o` follows `pulse_req_i` whenever the channel is not latched.
- R3: A high sample on a tick while idle starts the window. That tick counts as period 1 and `window_o` goes high. Trips in periods 1 to 8 only skip pulses and never latch.
- R4: A high sample on any tick in periods 9 to 16 of the window latches the channel: `fault_o` goes high and `window_o` goes low.
- R5: If periods 9 to 16 pass with no trip, `window_o` falls after the tick of period 16. A trip on the very next tick starts a fresh window as period 1.
- R6: While latched, `pulse_o` stays low and `fault_o` stays high, even when only one enable input is low.
- R7: A clock on which both `en_a_i` and `en_b_i` are low returns the block to idle on that clock. This clears fault, window and skip state and sets `skip_cnt_o` to 0. Comparator samples taken on such a clock are ignored.
- R8: `skip_cnt_o` counts the skipped periods of the current window. It is set to 1 by the trip that opens a window, rises by one for each further trip in periods 2 to 8, and holds its value until the next window or clear.
- R9: Asserting `rst_ni` low clears the latch, the counters and the state at once, without waiting for a clock edge.
- R10: Neither state nor counters change on clocks without `tick_i`, whatever the value of `oc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset (supply cycle) |
| tick_i | input | 1 | One-clock strobe per PWM period, sampled during low-side conduction |
| oc_i | input | 1 | Overcurrent comparator result, high = above threshold |
| pulse_req_i | input | 1 | Raw upper-switch pulse request from the modulator |
| en_a_i | input | 1 | First enable input |
| en_b_i | input | 1 | Second enable input |
| pulse_o | output | 1 | Gated upper-switch pulse |
| skip_o | output | 1 | Current period is being skipped |
| window_o | output | 1 | Observation window in progress |
| fault_o | output | 1 | Latched overcurrent fault, for the power-good logic |
| skip_cnt_o | output | 4 | Skipped periods in the current or last window |

## Verification
The embedded assertions check four properties on every clock:
- a latched channel holds until a double-low enable;
- a double-low enable always leaves the block idle;
- state and counters do not move without a tick;
- a blocked or latched channel never emits a pulse.

Only the bench scenarios can show the exact window boundaries. These are the trip on period 8 that must not latch, the trips on periods 9 and 16 that must latch, and the fresh window opened on period 17. The bench scenarios also cover the running skip count and the immediate effect of the asynchronous reset.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRACE = 2'd1,
    ST_WATCH = 2'd2,
    ST_LOCK  = 2'd3
  } ocp_state_e;
endpackage

// File: rtl/ocp_window_ctl.sv
module ocp_window_ctl
  import ocp_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 8,
  parameter int unsigned WATCH_CYC = 8,
  localparam int unsigned TOTAL_CYC = GRACE_CYC + WATCH_CYC,
  localparam int unsigned CNT_W = $clog2(TOTAL_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       oc_i,
  input  logic       clr_i,
  output ocp_state_e state_o,
  output logic       skip_o,
  output logic       win_start_o,
  output logic       skip_evt_o
);
  ocp_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic skip_q, skip_d;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    skip_d      = skip_q;
    win_start_o = 1'b0;
    skip_evt_o  = 1'b0;
    if (clr_i) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      skip_d = 1'b0;
    end else if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          skip_d = oc_i;
          if (oc_i) begin
            st_d        = ST_GRACE;
            cnt_d       = CNT_W'(1);
            win_start_o = 1'b1;
          end
        end
        ST_GRACE, ST_WATCH: begin
          if (cnt_inc <= CNT_W'(GRACE_CYC)) begin
            // grace phase: skip only
            skip_d     = oc_i;
            skip_evt_o = oc_i;
            cnt_d      = cnt_inc;
          end else if (oc_i) begin
            st_d   = ST_LOCK;
            cnt_d  = '0;
            skip_d = 1'b0;
          end else if (cnt_inc == CNT_W'(TOTAL_CYC)) begin
            st_d   = ST_IDLE;
            cnt_d  = '0;
            skip_d = 1'b0;
          end else begin
            st_d   = ST_WATCH;
            cnt_d  = cnt_inc;
            skip_d = 1'b0;
          end
        end
        default: skip_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      skip_q <= skip_d;
    end
  end

  assign state_o = st_q;
  assign skip_o  = skip_q;

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK && !clr_i) |=> st_q == ST_LOCK);
  p_clear_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (st_q == ST_IDLE && !skip_q));
  p_no_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> ($stable(st_q) && $stable(cnt_q) && $stable(skip_q)));
  p_grace_no_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GRACE && cnt_q < CNT_W'(GRACE_CYC)) |=> st_q != ST_LOCK);
  p_lock_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK && $past(st_q) != ST_LOCK) |-> $past(tick_i && oc_i));
  p_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TOTAL_CYC));
endmodule

// File: rtl/ocp_skip_gate.sv
module ocp_skip_gate #(
  parameter int unsigned GRACE_CYC = 8,
  localparam int unsigned SCNT_W = $clog2(GRACE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              win_start_i,
  input  logic              skip_evt_i,
  input  logic              skip_i,
  input  logic              lock_i,
  input  logic              pulse_req_i,
  output logic              pulse_o,
  output logic [SCNT_W-1:0] skip_cnt_o
);
  logic [SCNT_W-1:0] scnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          scnt_q <= '0;
    else if (clr_i)       scnt_q <= '0;
    else if (win_start_i) scnt_q <= SCNT_W'(1);
    else if (skip_evt_i && scnt_q != SCNT_W'(GRACE_CYC)) scnt_q <= scnt_q + 1'b1;
  end

  assign pulse_o    = pulse_req_i & ~skip_i & ~lock_i;
  assign skip_cnt_o = scnt_q;

  p_block_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_i || lock_i) |-> !pulse_o);
  p_scnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scnt_q <= SCNT_W'(GRACE_CYC));
endmodule

// File: rtl/ocp_seq.sv
module ocp_seq
  import ocp_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 8,
  parameter int unsigned WATCH_CYC = 8,
  localparam int unsigned SCNT_W = $clog2(GRACE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              oc_i,
  input  logic              pulse_req_i,
  input  logic              en_a_i,
  input  logic              en_b_i,
  output logic              pulse_o,
  output logic              skip_o,
  output logic              window_o,
  output logic              fault_o,
  output logic [SCNT_W-1:0] skip_cnt_o
);
  ocp_state_e st;
  logic clr, win_start, skip_evt, skip, lock;

  assign clr = ~en_a_i & ~en_b_i;

  ocp_window_ctl #(.GRACE_CYC(GRACE_CYC), .WATCH_CYC(WATCH_CYC)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .oc_i(oc_i), .clr_i(clr),
    .state_o(st), .skip_o(skip), .win_start_o(win_start), .skip_evt_o(skip_evt)
  );

  assign lock = (st == ST_LOCK);

  ocp_skip_gate #(.GRACE_CYC(GRACE_CYC)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .win_start_i(win_start),
    .skip_evt_i(skip_evt), .skip_i(skip), .lock_i(lock),
    .pulse_req_i(pulse_req_i), .pulse_o(pulse_o), .skip_cnt_o(skip_cnt_o)
  );

  assign skip_o   = skip;
  assign fault_o  = lock;
  assign window_o = (st == ST_GRACE) || (st == ST_WATCH);

  p_fault_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !pulse_o);
  p_fault_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && window_o));
endmodule

// File: tb/sim_ocp_seq.sv
`timescale 1ns/1ps
module sim_ocp_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, oc = 0, req = 0, en_a = 1, en_b = 1;
  logic pulse, skip, win, fault;
  logic [3:0] scnt;
  int total = 0, bad = 0;
  bit done = 0;

  // reference model state: 0 idle, 1 grace, 2 watch, 3 lock
  int m_st = 0, m_cnt = 0, m_scnt = 0;
  bit m_skip = 0;

  always #2.5 clk = ~clk;

  ocp_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .oc_i(oc), .pulse_req_i(req),
    .en_a_i(en_a), .en_b_i(en_b), .pulse_o(pulse), .skip_o(skip),
    .window_o(win), .fault_o(fault), .skip_cnt_o(scnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_st = 0; m_cnt = 0; m_scnt = 0; m_skip = 0;
  endtask

  task automatic m_tick(input bit o);
    int n;
    case (m_st)
      0: begin
        m_skip = o;
        if (o) begin m_st = 1; m_cnt = 1; m_scnt = 1; end
      end
      1, 2: begin
        n = m_cnt + 1;
        if (n <= 8) begin
          m_skip = o; m_cnt = n;
          if (o && m_scnt < 8) m_scnt++;
        end else if (o) begin
          m_st = 3; m_cnt = 0; m_skip = 0;
        end else if (n == 16) begin
          m_st = 0; m_cnt = 0; m_skip = 0;
        end else begin
          m_st = 2; m_cnt = n; m_skip = 0;
        end
      end
      default: m_skip = 0;
    endcase
  endtask

  function automatic bit exp_pulse(input bit r);
    return r && !m_skip && m_st != 3;
  endfunction

  task automatic cmp_all();
    chk("R1/R2 pulse_o", pulse, exp_pulse(req));
    chk("R1 skip_o", skip, m_skip);
    chk("R3/R5 window_o", win, (m_st == 1 || m_st == 2));
    chk("R4/R6 fault_o", fault, (m_st == 3));
    chk("R8 skip_cnt_o", scnt, m_scnt);
  endtask

  // one clock: drive, edge, model, sample at negedge
  task automatic step(input bit t, input bit o, input bit ea, input bit eb);
    tick = t; oc = o; en_a = ea; en_b = eb;
    @(posedge clk);
    if (!ea && !eb) m_reset();
    else if (t) m_tick(o);
    @(negedge clk);
    req = 1'b1;
    #0.1;
    cmp_all();
  endtask

  task automatic period(input bit o);
    step(1, o, 1, 1);
    step(0, ~o, 1, 1);
  endtask

  task automatic clear_all();
    step(0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    req = 1;
    #1;
    chk("R9 reset fault_o", fault, 0);
    chk("R9 reset window_o", win, 0);
    chk("R9 reset skip_cnt_o", scnt, 0);
    chk("R2 reset pulse_o", pulse, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R10: oc high without tick has no effect
    for (int i = 0; i < 5; i++) step(0, 1, 1, 1);
    chk("R10 no tick window_o", win, 0);
    chk("R10 no tick pulse_o", pulse, 1);

    // R3: trips on every grace period including period 8, no latch
    for (int i = 1; i <= 8; i++) period(1);
    chk("R3 grace no latch fault_o", fault, 0);
    chk("R8 eight skips", scnt, 8);
    period(0); // period 9 clean
    chk("R2 released pulse_o", pulse, 1);
    for (int i = 10; i <= 15; i++) period(0);
    chk("R5 still in window at 15", win, 1);
    period(0); // period 16
    chk("R5 window closed after 16", win, 0);
    period(1); // fresh trip = period 1
    chk("R5 fresh window", win, 1);
    chk("R5 fresh count", scnt, 1);
    chk("R1 skip on trip", pulse, 0);
    clear_all();

    // R4: trip at period 9 latches
    period(1);
    for (int i = 2; i <= 8; i++) period(0);
    period(1);
    chk("R4 latch at 9", fault, 1);
    chk("R6 pulse off", pulse, 0);
    step(0, 0, 0, 1);
    chk("R6 single en low keeps fault", fault, 1);
    step(0, 0, 1, 0);
    chk("R6 other en low keeps fault", fault, 1);
    step(1, 1, 0, 0);
    chk("R7 double low clears", fault, 0);
    chk("R7 oc ignored while cleared", win, 0);
    chk("R7 count cleared", scnt, 0);

    // R4: trip at period 16 latches
    period(1);
    for (int i = 2; i <= 15; i++) period(0);
    period(1);
    chk("R4 latch at 16", fault, 1);

    // R9: async reset while latched
    #0.5 rst_n = 1'b0;
    #0.5;
    chk("R9 async clear fault", fault, 0);
    m_reset();
    @(negedge clk); rst_n = 1'b1;

    // random regimes
    for (int g = 0; g < 4; g++) begin
      int pct;
      pct = (g == 0) ? 5 : (g == 1) ? 20 : (g == 2) ? 50 : 90;
      for (int k = 0; k < 300; k++) begin
        bit o, ea, eb;
        int r;
        o  = ($urandom % 100) < pct;
        r  = $urandom % 60;
        ea = (r != 0 && r != 1);
        eb = (r != 0 && r != 2);
        step(1, o, ea, eb);
        step(0, $urandom % 2, 1, 1);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule